// File: doc/BRIEF.md
# Lockable GPIO Register Interface

This block is the software-facing register front end of a 32-pin GPIO controller. It decodes word-aligned 32-bit reads and writes on a simple valid/write/address/data bus within a 4 KiB window. It holds the configuration words that the pin-resolution and event blocks use, and it drives those words straight out as ports. Those neighbouring blocks are separate. The pin input word and the event status word come in from them and can be read back through the bus.

Writes that touch pin-facing configuration produce a one-cycle update pulse. The pulse names the word that changed and carries a mask of the bits that moved, so the pin resolver only re-evaluates what is needed. Data-out and output-enable each have write-one-to-set and write-one-to-clear alias addresses, and so does the event-enable word. Software can therefore flip single pins without a read-modify-write.

A two-key lock protects the whole configuration. A write to either key address engages the lock. Once locked, every configuration write is discarded and flagged. Only a second key loaded with one magic word, followed by the first key written with another magic word, releases the lock.

Top module: `gpio_cfg_regs`

## Requirements
- R1: After reset the lock is released, every configuration word is zero, and the pull-up, pull-down, slew and strength words hold their per-pin reset parameters.
- R2: A write to a read-write configuration address stores the word. A read returns the stored word on `rsp_rdata` in the cycle after the request, and `rsp_rdata` is zero in any cycle that does not follow a read.
- R3: The set aliases DRV_SET 0x68, OEN_SET 0x70 and EN_SET 0x44 OR the written word into data-out (0x0C), output-enable (0x10) and event-enable (0x40) respectively. The clear aliases DRV_CLR 0x6C, OEN_CLR 0x74 and EN_CLR 0x48 AND those same targets with the inverted written word.
- R4: A write to inversion 0x08, data-out 0x0C, output-enable 0x10, open-drain 0x14, pull-up 0x1C, pull-down 0x20 or input-enable 0x58 raises `upd_valid` for one cycle after the request. On that cycle `upd_sel` is 0, 1, 2, 3, 4, 5 or 6 respectively. For a direct write, `upd_mask` is old XOR new; for a data-out or output-enable alias write it is the written word. No other write raises `upd_valid`.
- R5: While released, a write of any value to key A (0x00) or key B (0x7C) engages the lock, and key A then reads 1.
- R6: While locked, every write except those to the two keys leaves all configuration words unchanged, gives no update pulse, and raises `rsp_err` for one cycle.
- R7: While locked, a write to key B stores its value. A write of 0xC0DEFA73 to key A releases the lock and clears both keys only when key B holds 0xC0DE1248. Any other key A write leaves the lock engaged. Neither key write raises `rsp_err`.
- R8: Reads of the write-only addresses (0x44, 0x48, 0x68, 0x6C, 0x70, 0x74 and key B 0x7C) return zero and raise `rsp_err`.
- R9: Reads of 0x04 return `pin_din` and reads of 0x4C return `ev_status`. A write to 0x04 changes nothing and raises `rsp_err`.
- R10: A released write to event status 0x4C drives the written word onto `ev_clear` for one cycle.
- R11: An access to an undefined offset, or to an address whose two low bits are not zero, reads zero, changes nothing and raises `rsp_err` for one cycle.
- R12: Reads work the same while the lock is engaged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte address in the window |
| req_wdata | input | WORD_W (32) | Write data |
| pin_din | input | WORD_W | Resolved input word from the pin block |
| ev_status | input | WORD_W | Event status word from the event block |
| rsp_rdata | output | WORD_W | Read data, one cycle after a read |
| rsp_err | output | 1 | Illegal access, one cycle after the request |
| upd_valid | output | 1 | Pin-facing word changed |
| upd_sel | output | 4 | Which pin-facing word changed (see R4) |
| upd_mask | output | WORD_W | Bits reported as changed |
| ev_clear | output | WORD_W | Event status bits to clear |
| locked | output | 1 | Lock engaged |
| cfg_inv | output | WORD_W | Input/output polarity inversion |
| cfg_drv | output | WORD_W | Data-out |
| cfg_oen | output | WORD_W | Output enable |
| cfg_odrn | output | WORD_W | Open-drain select |
| cfg_vsel | output | WORD_W | Stored-only pad option word (0x18) |
| cfg_pullup | output | WORD_W | Pull-up enable |
| cfg_pulldn | output | WORD_W | Pull-down enable |
| cfg_debounce | output | WORD_W | Debounce enable (0x24) |
| cfg_ev_edge | output | WORD_W | Event edge (1) or level (0) select (0x28) |
| cfg_ev_both | output | WORD_W | Event on both edges (0x2C) |
| cfg_ev_en | output | WORD_W | Event enable |
| cfg_in_en | output | WORD_W | Input enable mask |
| cfg_slew | output | WORD_W | Slew rate select (0x5C) |
| cfg_strength | output | WORD_W | Drive strength select (0x60) |

## Verification
The bound checker watches several rules on every cycle. A misaligned access always errors with zero data. A locked non-key write never moves data-out or output-enable. A released key write always engages the lock. A data-out set alias always ORs into the old word. Idle cycles stay silent, and the update pulse never coincides with an error. Other behaviours depend on an ordered history, and only the bench scenarios can show them: the two-step unlock and its wrong-order and wrong-value cases, the exact XOR masks across a series of writes, and the reset loading of parameter values.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;

   localparam int NUM_CFG     = 14;
   localparam int NUM_PIN_CFG = 7;

   // pin-facing words come first so their index doubles as the update code
   typedef enum logic [3:0] {
      CFG_INV      = 4'd0,
      CFG_DRV      = 4'd1,
      CFG_OEN      = 4'd2,
      CFG_ODRN     = 4'd3,
      CFG_PULLUP   = 4'd4,
      CFG_PULLDN   = 4'd5,
      CFG_IN_EN    = 4'd6,
      CFG_VSEL     = 4'd7,
      CFG_DEBOUNCE = 4'd8,
      CFG_EV_EDGE  = 4'd9,
      CFG_EV_BOTH  = 4'd10,
      CFG_EV_EN    = 4'd11,
      CFG_SLEW     = 4'd12,
      CFG_STRENGTH = 4'd13
   } cfg_idx_e;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_LOAD,
      OP_SET,
      OP_CLEAR
   } cfg_op_e;

   typedef enum logic [2:0] {
      ACC_CFG,
      ACC_KEY_A,
      ACC_KEY_B,
      ACC_DIN,
      ACC_EV_STAT,
      ACC_SET,
      ACC_CLEAR,
      ACC_UNDEF
   } acc_kind_e;

   typedef struct packed {
      acc_kind_e kind;
      cfg_idx_e  idx;
   } dec_t;

   localparam logic [31:0] RELEASE_WORD_A = 32'hC0DE_FA73;
   localparam logic [31:0] RELEASE_WORD_B = 32'hC0DE_1248;

   function automatic dec_t word_decode(input logic [15:0] widx);
      dec_t d;
      d.kind = ACC_CFG;
      d.idx  = CFG_INV;
      case (widx)
         16'd0:   d.kind = ACC_KEY_A;
         16'd1:   d.kind = ACC_DIN;
         16'd2:   d.idx  = CFG_INV;
         16'd3:   d.idx  = CFG_DRV;
         16'd4:   d.idx  = CFG_OEN;
         16'd5:   d.idx  = CFG_ODRN;
         16'd6:   d.idx  = CFG_VSEL;
         16'd7:   d.idx  = CFG_PULLUP;
         16'd8:   d.idx  = CFG_PULLDN;
         16'd9:   d.idx  = CFG_DEBOUNCE;
         16'd10:  d.idx  = CFG_EV_EDGE;
         16'd11:  d.idx  = CFG_EV_BOTH;
         16'd16:  d.idx  = CFG_EV_EN;
         16'd17:  begin d.kind = ACC_SET;   d.idx = CFG_EV_EN; end
         16'd18:  begin d.kind = ACC_CLEAR; d.idx = CFG_EV_EN; end
         16'd19:  d.kind = ACC_EV_STAT;
         16'd22:  d.idx  = CFG_IN_EN;
         16'd23:  d.idx  = CFG_SLEW;
         16'd24:  d.idx  = CFG_STRENGTH;
         16'd26:  begin d.kind = ACC_SET;   d.idx = CFG_DRV; end
         16'd27:  begin d.kind = ACC_CLEAR; d.idx = CFG_DRV; end
         16'd28:  begin d.kind = ACC_SET;   d.idx = CFG_OEN; end
         16'd29:  begin d.kind = ACC_CLEAR; d.idx = CFG_OEN; end
         16'd31:  d.kind = ACC_KEY_B;
         default: d.kind = ACC_UNDEF;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/gpio_cfg_decode.sv
module gpio_cfg_decode
   import gpio_cfg_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              aligned,
   output dec_t              dec
);

   localparam int WIDX_W = ADDR_W - 2;

   logic [15:0] widx;

   generate
      if (WIDX_W >= 16) begin : g_wide
         assign widx = addr[17:2];
      end else begin : g_narrow
         assign widx = {{(16 - WIDX_W){1'b0}}, addr[ADDR_W-1:2]};
      end
   endgenerate

   assign aligned = (addr[1:0] == 2'b00);
   assign dec     = word_decode(widx);

endmodule

// File: rtl/gpio_cfg_lock.sv
module gpio_cfg_lock
   import gpio_cfg_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_key_a,
   input  logic              wr_key_b,
   input  logic [WORD_W-1:0] wdata,
   output logic              locked,
   output logic [WORD_W-1:0] key_a_q
);

   logic [WORD_W-1:0] key_b_q;
   logic              release_ok;

   assign locked     = (key_a_q == WORD_W'(1));
   assign release_ok = (key_b_q == WORD_W'(RELEASE_WORD_B)) &&
                       (wdata == WORD_W'(RELEASE_WORD_A));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_a_q <= '0;
         key_b_q <= '0;
      end else if (locked) begin
         if (wr_key_b) begin
            key_b_q <= wdata;
         end else if (wr_key_a && release_ok) begin
            key_a_q <= '0;
            key_b_q <= '0;
         end
      end else if (wr_key_a || wr_key_b) begin
         key_a_q <= WORD_W'(1);
         key_b_q <= '0;
      end
   end

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
   import gpio_cfg_pkg::*;
#(
   parameter int                WORD_W       = 32,
   parameter logic [WORD_W-1:0] RST_PULLUP   = '0,
   parameter logic [WORD_W-1:0] RST_PULLDN   = '0,
   parameter logic [WORD_W-1:0] RST_SLEW     = '0,
   parameter logic [WORD_W-1:0] RST_STRENGTH = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cfg_op_e           op,
   input  cfg_idx_e          idx,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] words [NUM_CFG]
);

   generate
      for (genvar g = 0; g < NUM_CFG; g++) begin : g_word
         localparam logic [WORD_W-1:0] RST_VAL =
            (g == int'(CFG_PULLUP))   ? RST_PULLUP   :
            (g == int'(CFG_PULLDN))   ? RST_PULLDN   :
            (g == int'(CFG_SLEW))     ? RST_SLEW     :
            (g == int'(CFG_STRENGTH)) ? RST_STRENGTH : '0;

         logic [WORD_W-1:0] q;
         logic              hit;

         assign hit      = (op != OP_NONE) && (idx == cfg_idx_e'(g));
         assign words[g] = q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= RST_VAL;
            end else if (hit) begin
               case (op)
                  OP_LOAD:  q <= wdata;
                  OP_SET:   q <= q | wdata;
                  OP_CLEAR: q <= q & ~wdata;
                  default:  q <= q;
               endcase
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_cfg_pkg::*;
#(
   parameter int                ADDR_W       = 12,
   parameter int                WORD_W       = 32,
   parameter logic [WORD_W-1:0] RST_PULLUP   = '0,
   parameter logic [WORD_W-1:0] RST_PULLDN   = '0,
   parameter logic [WORD_W-1:0] RST_SLEW     = '0,
   parameter logic [WORD_W-1:0] RST_STRENGTH = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [WORD_W-1:0] req_wdata,
   input  logic [WORD_W-1:0] pin_din,
   input  logic [WORD_W-1:0] ev_status,
   output logic [WORD_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              upd_valid,
   output logic [3:0]        upd_sel,
   output logic [WORD_W-1:0] upd_mask,
   output logic [WORD_W-1:0] ev_clear,
   output logic              locked,
   output logic [WORD_W-1:0] cfg_inv,
   output logic [WORD_W-1:0] cfg_drv,
   output logic [WORD_W-1:0] cfg_oen,
   output logic [WORD_W-1:0] cfg_odrn,
   output logic [WORD_W-1:0] cfg_vsel,
   output logic [WORD_W-1:0] cfg_pullup,
   output logic [WORD_W-1:0] cfg_pulldn,
   output logic [WORD_W-1:0] cfg_debounce,
   output logic [WORD_W-1:0] cfg_ev_edge,
   output logic [WORD_W-1:0] cfg_ev_both,
   output logic [WORD_W-1:0] cfg_ev_en,
   output logic [WORD_W-1:0] cfg_in_en,
   output logic [WORD_W-1:0] cfg_slew,
   output logic [WORD_W-1:0] cfg_strength
);

   generate
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W must reach the top key address");
      end
      if (WORD_W != 32) begin : g_bad_word
         $error("WORD_W must be 32 to match the release words");
      end
   endgenerate

   logic              aligned;
   dec_t              dec;
   logic [WORD_W-1:0] words [NUM_CFG];
   logic [WORD_W-1:0] key_a_q;
   logic              wr_key_a, wr_key_b;
   cfg_op_e           b_op;
   logic              wr_err, rd_err, upd_n;
   logic [WORD_W-1:0] mask_n, clr_n, rd_val, old_word;
   logic              do_wr, do_rd, pin_word;

   gpio_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr    (req_addr),
      .aligned (aligned),
      .dec     (dec)
   );

   gpio_cfg_lock #(.WORD_W(WORD_W)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_key_a (wr_key_a),
      .wr_key_b (wr_key_b),
      .wdata    (req_wdata),
      .locked   (locked),
      .key_a_q  (key_a_q)
   );

   gpio_cfg_bank #(
      .WORD_W       (WORD_W),
      .RST_PULLUP   (RST_PULLUP),
      .RST_PULLDN   (RST_PULLDN),
      .RST_SLEW     (RST_SLEW),
      .RST_STRENGTH (RST_STRENGTH)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (b_op),
      .idx   (dec.idx),
      .wdata (req_wdata),
      .words (words)
   );

   assign do_wr    = req_valid && req_write;
   assign do_rd    = req_valid && !req_write;
   assign old_word = words[dec.idx];
   assign pin_word = (dec.idx < cfg_idx_e'(NUM_PIN_CFG));

   // write path
   always_comb begin
      b_op     = OP_NONE;
      wr_err   = 1'b0;
      wr_key_a = 1'b0;
      wr_key_b = 1'b0;
      upd_n    = 1'b0;
      mask_n   = '0;
      clr_n    = '0;
      if (do_wr) begin
         if (!aligned) begin
            wr_err = 1'b1;
         end else if (locked) begin
            case (dec.kind)
               ACC_KEY_A: wr_key_a = 1'b1;
               ACC_KEY_B: wr_key_b = 1'b1;
               default:   wr_err   = 1'b1;
            endcase
         end else begin
            case (dec.kind)
               ACC_KEY_A: wr_key_a = 1'b1;
               ACC_KEY_B: wr_key_b = 1'b1;
               ACC_CFG: begin
                  b_op   = OP_LOAD;
                  upd_n  = pin_word;
                  mask_n = old_word ^ req_wdata;
               end
               ACC_SET: begin
                  b_op   = OP_SET;
                  upd_n  = pin_word;
                  mask_n = req_wdata;
               end
               ACC_CLEAR: begin
                  b_op   = OP_CLEAR;
                  upd_n  = pin_word;
                  mask_n = req_wdata;
               end
               ACC_EV_STAT: clr_n = req_wdata;
               default:     wr_err = 1'b1;
            endcase
         end
      end
   end

   // read path
   always_comb begin
      rd_val = '0;
      rd_err = 1'b0;
      if (do_rd) begin
         if (!aligned) begin
            rd_err = 1'b1;
         end else begin
            case (dec.kind)
               ACC_CFG:     rd_val = old_word;
               ACC_KEY_A:   rd_val = key_a_q;
               ACC_DIN:     rd_val = pin_din;
               ACC_EV_STAT: rd_val = ev_status;
               default:     rd_err = 1'b1;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_rdata <= '0;
         rsp_err   <= 1'b0;
         upd_valid <= 1'b0;
         upd_sel   <= '0;
         upd_mask  <= '0;
         ev_clear  <= '0;
      end else begin
         rsp_rdata <= rd_val;
         rsp_err   <= rd_err | wr_err;
         upd_valid <= upd_n;
         upd_sel   <= upd_n ? dec.idx : 4'd0;
         upd_mask  <= upd_n ? mask_n : '0;
         ev_clear  <= clr_n;
      end
   end

   assign cfg_inv      = words[CFG_INV];
   assign cfg_drv      = words[CFG_DRV];
   assign cfg_oen      = words[CFG_OEN];
   assign cfg_odrn     = words[CFG_ODRN];
   assign cfg_vsel     = words[CFG_VSEL];
   assign cfg_pullup   = words[CFG_PULLUP];
   assign cfg_pulldn   = words[CFG_PULLDN];
   assign cfg_debounce = words[CFG_DEBOUNCE];
   assign cfg_ev_edge  = words[CFG_EV_EDGE];
   assign cfg_ev_both  = words[CFG_EV_BOTH];
   assign cfg_ev_en    = words[CFG_EV_EN];
   assign cfg_in_en    = words[CFG_IN_EN];
   assign cfg_slew     = words[CFG_SLEW];
   assign cfg_strength = words[CFG_STRENGTH];

endmodule

// File: rtl/gpio_cfg_regs_chk.sv
module gpio_cfg_regs_chk #(
   parameter int ADDR_W = 12,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [WORD_W-1:0] req_wdata,
   input logic [WORD_W-1:0] rsp_rdata,
   input logic              rsp_err,
   input logic              upd_valid,
   input logic [3:0]        upd_sel,
   input logic              locked,
   input logic [WORD_W-1:0] cfg_drv,
   input logic [WORD_W-1:0] cfg_oen
);

   localparam logic [ADDR_W-1:0] A_KEY_A   = ADDR_W'(12'h000);
   localparam logic [ADDR_W-1:0] A_KEY_B   = ADDR_W'(12'h07C);
   localparam logic [ADDR_W-1:0] A_DRV_SET = ADDR_W'(12'h068);

   // R11
   misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_addr[1:0] != 2'b00) |=> rsp_err && (rsp_rdata == '0) && !upd_valid);

   // R6
   locked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && locked && (req_addr != A_KEY_A) && (req_addr != A_KEY_B)
      |=> rsp_err && !upd_valid && $stable(cfg_drv) && $stable(cfg_oen));

   // R5
   engage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && !locked && ((req_addr == A_KEY_A) || (req_addr == A_KEY_B))
      |=> locked);

   // R3
   drv_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_write && !locked && (req_addr == A_DRV_SET)
      |=> cfg_drv == ($past(cfg_drv) | $past(req_wdata)));

   // R4
   upd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |-> !rsp_err && (upd_sel < 4'd7));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_err && !upd_valid && (rsp_rdata == '0));

   // R8
   key_b_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_write && (req_addr == A_KEY_B) |=> rsp_err && (rsp_rdata == '0));

endmodule

bind gpio_cfg_regs gpio_cfg_regs_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .rsp_rdata (rsp_rdata),
   .rsp_err   (rsp_err),
   .upd_valid (upd_valid),
   .upd_sel   (upd_sel),
   .locked    (locked),
   .cfg_drv   (cfg_drv),
   .cfg_oen   (cfg_oen)
);

// File: tb/gpio_cfg_regs_test.sv
`timescale 1ns/1ps
module gpio_cfg_regs_test;

   localparam logic [31:0] P_PU = 32'h0000_00F0;
   localparam logic [31:0] P_PD = 32'h0F00_0000;
   localparam logic [31:0] P_SL = 32'h0000_0001;
   localparam logic [31:0] P_ST = 32'h8000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] pin_din = 32'hA5A5_0001;
   logic [31:0] ev_status = 32'h0000_F00D;
   logic [31:0] rsp_rdata, upd_mask, ev_clear;
   logic        rsp_err, upd_valid, locked;
   logic [3:0]  upd_sel;
   logic [31:0] cfg_inv, cfg_drv, cfg_oen, cfg_odrn, cfg_vsel, cfg_pullup, cfg_pulldn;
   logic [31:0] cfg_debounce, cfg_ev_edge, cfg_ev_both, cfg_ev_en, cfg_in_en, cfg_slew, cfg_strength;

   int checks = 0;
   int fails  = 0;

   typedef struct {
      logic [31:0] rdata;
      logic        err;
      logic        upd;
      logic [3:0]  sel;
      logic [31:0] mask;
      logic [31:0] clr;
      string       req;
   } exp_t;

   exp_t sb[$];

   always #2.5 clk = ~clk;

   gpio_cfg_regs #(
      .RST_PULLUP(P_PU), .RST_PULLDN(P_PD), .RST_SLEW(P_SL), .RST_STRENGTH(P_ST)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .pin_din(pin_din), .ev_status(ev_status),
      .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .upd_valid(upd_valid), .upd_sel(upd_sel),
      .upd_mask(upd_mask), .ev_clear(ev_clear), .locked(locked),
      .cfg_inv(cfg_inv), .cfg_drv(cfg_drv), .cfg_oen(cfg_oen), .cfg_odrn(cfg_odrn),
      .cfg_vsel(cfg_vsel), .cfg_pullup(cfg_pullup), .cfg_pulldn(cfg_pulldn),
      .cfg_debounce(cfg_debounce), .cfg_ev_edge(cfg_ev_edge), .cfg_ev_both(cfg_ev_both),
      .cfg_ev_en(cfg_ev_en), .cfg_in_en(cfg_in_en), .cfg_slew(cfg_slew), .cfg_strength(cfg_strength)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   // driver: queue the expected response, then present one request for one cycle
   task automatic xact(input logic w, input logic [11:0] a, input logic [31:0] d,
                       input logic [31:0] er, input logic ee, input logic eu,
                       input logic [3:0] es, input logic [31:0] em, input logic [31:0] ec,
                       input string req);
      exp_t e;
      e.rdata = er; e.err = ee; e.upd = eu; e.sel = es; e.mask = em; e.clr = ec; e.req = req;
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic ee,
                     input logic eu, input logic [3:0] es, input logic [31:0] em, input string req);
      xact(1'b1, a, d, 32'h0, ee, eu, es, em, 32'h0, req);
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] er, input logic ee, input string req);
      xact(1'b0, a, 32'h0, er, ee, 1'b0, 4'd0, 32'h0, 32'h0, req);
   endtask

   // monitor: one response per accepted request, sampled 1 ns after the edge
   always @(posedge clk) begin
      if (rst_n && req_valid) begin
         #1;
         checks++;
         if (sb.size() == 0) begin
            fails++;
            $display("FAIL scoreboard: response with no expected item");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_rdata !== e.rdata || rsp_err !== e.err || upd_valid !== e.upd ||
                upd_sel !== e.sel || upd_mask !== e.mask || ev_clear !== e.clr) begin
               fails++;
               $display("FAIL %s: actual rd=%08h err=%0b upd=%0b sel=%0d mask=%08h clr=%08h expected rd=%08h err=%0b upd=%0b sel=%0d mask=%08h clr=%08h",
                        e.req, rsp_rdata, rsp_err, upd_valid, upd_sel, upd_mask, ev_clear,
                        e.rdata, e.err, e.upd, e.sel, e.mask, e.clr);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pullup", cfg_pullup, P_PU);
      chk("R1 pulldn", cfg_pulldn, P_PD);
      chk("R1 slew", cfg_slew, P_SL);
      chk("R1 strength", cfg_strength, P_ST);
      chk("R1 drv", cfg_drv, 32'h0);
      chk("R1 ev_en", cfg_ev_en, 32'h0);
      chk("R1 locked", {31'h0, locked}, 32'h0);

      // R2 R4 direct writes and read back
      wr(12'h00C, 32'h0000_00FF, 1'b0, 1'b1, 4'd1, 32'h0000_00FF, "R4 drv first");
      rd(12'h00C, 32'h0000_00FF, 1'b0, "R2 drv readback");
      wr(12'h00C, 32'h0000_0F0F, 1'b0, 1'b1, 4'd1, 32'h0000_0FF0, "R4 drv xor mask");
      wr(12'h058, 32'h0000_0003, 1'b0, 1'b1, 4'd6, 32'h0000_0003, "R4 in_en code");
      wr(12'h024, 32'h0000_0055, 1'b0, 1'b0, 4'd0, 32'h0, "R4 debounce no update");
      chk("R2 debounce stored", cfg_debounce, 32'h0000_0055);

      // R3 aliases
      wr(12'h068, 32'hF000_0000, 1'b0, 1'b1, 4'd1, 32'hF000_0000, "R3 drv set");
      wr(12'h06C, 32'h0000_000F, 1'b0, 1'b1, 4'd1, 32'h0000_000F, "R3 drv clear");
      chk("R3 drv after alias", cfg_drv, 32'hF000_0F00);
      wr(12'h070, 32'h0000_0101, 1'b0, 1'b1, 4'd2, 32'h0000_0101, "R3 oen set");
      wr(12'h074, 32'h0000_0001, 1'b0, 1'b1, 4'd2, 32'h0000_0001, "R3 oen clear");
      chk("R3 oen after alias", cfg_oen, 32'h0000_0100);
      wr(12'h044, 32'h0000_0030, 1'b0, 1'b0, 4'd0, 32'h0, "R3 ev_en set");
      wr(12'h048, 32'h0000_0010, 1'b0, 1'b0, 4'd0, 32'h0, "R3 ev_en clear");
      chk("R3 ev_en after alias", cfg_ev_en, 32'h0000_0020);

      // R9 R10 inputs and event clear
      rd(12'h004, 32'hA5A5_0001, 1'b0, "R9 din read");
      rd(12'h04C, 32'h0000_F00D, 1'b0, "R9 ev_status read");
      wr(12'h004, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd0, 32'h0, "R9 din write");
      xact(1'b1, 12'h04C, 32'h0000_000D, 32'h0, 1'b0, 1'b0, 4'd0, 32'h0, 32'h0000_000D, "R10 ev clear");

      // R8 write-only reads
      rd(12'h068, 32'h0, 1'b1, "R8 drv set read");
      rd(12'h044, 32'h0, 1'b1, "R8 ev_en set read");
      rd(12'h07C, 32'h0, 1'b1, "R8 key_b read");

      // R11 undefined and misaligned
      rd(12'h030, 32'h0, 1'b1, "R11 undefined read");
      wr(12'h050, 32'h1234_5678, 1'b1, 1'b0, 4'd0, 32'h0, "R11 undefined write");
      wr(12'h00E, 32'h0, 1'b1, 1'b0, 4'd0, 32'h0, "R11 misaligned write");
      chk("R11 drv untouched", cfg_drv, 32'hF000_0F00);

      // R5 engage by key B
      wr(12'h07C, 32'h0000_1234, 1'b0, 1'b0, 4'd0, 32'h0, "R5 engage via key B");
      chk("R5 locked", {31'h0, locked}, 32'h1);
      rd(12'h000, 32'h1, 1'b0, "R5 R12 key A reads one");

      // R6 R12 writes blocked while locked
      wr(12'h00C, 32'h0, 1'b1, 1'b0, 4'd0, 32'h0, "R6 drv blocked");
      wr(12'h06C, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'd0, 32'h0, "R6 alias blocked");
      rd(12'h00C, 32'hF000_0F00, 1'b0, "R6 R12 drv kept");

      // R7 unlock sequence
      wr(12'h000, 32'hC0DE_FA73, 1'b0, 1'b0, 4'd0, 32'h0, "R7 key A without key B");
      chk("R7 still locked", {31'h0, locked}, 32'h1);
      wr(12'h07C, 32'hC0DE_1248, 1'b0, 1'b0, 4'd0, 32'h0, "R7 load key B");
      wr(12'h000, 32'h0BAD_0BAD, 1'b0, 1'b0, 4'd0, 32'h0, "R7 wrong key A");
      chk("R7 locked after wrong", {31'h0, locked}, 32'h1);
      wr(12'h000, 32'hC0DE_FA73, 1'b0, 1'b0, 4'd0, 32'h0, "R7 release");
      chk("R7 released", {31'h0, locked}, 32'h0);
      rd(12'h000, 32'h0, 1'b0, "R7 key A cleared");
      wr(12'h00C, 32'hF000_0F01, 1'b0, 1'b1, 4'd1, 32'h0000_0001, "R7 write after release");

      // R5 engage by key A, then release again
      wr(12'h000, 32'h0000_0000, 1'b0, 1'b0, 4'd0, 32'h0, "R5 engage via key A");
      chk("R5 locked by key A", {31'h0, locked}, 32'h1);
      wr(12'h07C, 32'hC0DE_1248, 1'b0, 1'b0, 4'd0, 32'h0, "R7 reload key B");
      wr(12'h000, 32'hC0DE_FA73, 1'b0, 1'b0, 4'd0, 32'h0, "R7 second release");
      chk("R7 second released", {31'h0, locked}, 32'h0);

      repeat (2) @(negedge clk);
      chk("scoreboard drained", sb.size(), 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule